// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a stream of signed acceleration samples and reports short impulses. It takes one sample per strobe, either from a single axis or from a combined magnitude. An impulse is a run of samples whose absolute value is above a programmable threshold. The block classifies each impulse as a single tap or as the first half of a double tap. All timing is counted in sample periods. The limits are a maximum impulse length, a quiet latency after the first impulse, and a window in which a second impulse may begin.

The controller is an explicit state machine with seven states:

- `ST_IDLE`: waiting for a first impulse.
- `ST_FIRST`: counting the first impulse.
- `ST_LATENT`: the dead time after the first impulse.
- `ST_WIN_LOW`: the window is open, but the signal was still high when it opened, so it must drop first.
- `ST_WIN_ARM`: the window is open and a rising crossing starts the second impulse.
- `ST_SECOND`: counting the second impulse.
- `ST_OVER`: an impulse that ran too long; the block waits for the signal to drop.

The transitions are:

- IDLE→FIRST on a crossing.
- FIRST→IDLE when the impulse ends and only single taps are in use.
- FIRST→LATENT when the impulse ends and double taps are in use.
- FIRST→OVER when the impulse runs too long.
- LATENT→WIN_LOW or LATENT→WIN_ARM when the latency expires, chosen by the level of the last latency sample.
- WIN_LOW→WIN_ARM when the signal drops.
- WIN_ARM→SECOND on a crossing.
- WIN_LOW→IDLE or WIN_ARM→IDLE when the window expires.
- SECOND→IDLE on a valid second impulse.
- SECOND→OVER when the second impulse runs too long.
- OVER→IDLE when the signal drops.

When double taps are in use, the single-tap report is deferred until the double-tap attempt is settled.

Top module: `tap_classifier`

## Requirements
- R1: A sample counts as high when its absolute value, taken as an unsigned number, is strictly greater than `thresh`. A magnitude equal to `thresh` is low. The most negative sample has magnitude 2^(SAMPLE_W-1).
- R2: A run of N consecutive high samples is a valid impulse only if N ≤ `dur_max`. A longer run gives no pulse, and the block stays busy until a low sample arrives.
- R3: With only single taps in use, `single_tap` pulses for the first low sample that ends a valid impulse.
- R4: The latency covers the `latency` samples that follow the sample ending the first impulse. High samples during the latency never start a second impulse.
- R5: The window covers the `window` samples that follow the latency. A second impulse starts on a window sample that is high while the block is armed. The block is armed at window open only if the last latency sample was low; otherwise it arms after a low window sample.
- R6: A second impulse that starts in the window may end after the window closes. If its length is ≤ `dur_max`, `double_tap` pulses for its ending low sample.
- R7: With both tap kinds in use, `single_tap` pulses once the double attempt settles. It falls in the same cycle as `double_tap` on success. On failure it falls on the last window sample or on the sample where the second impulse exceeds `dur_max`.
- R8: A failed double attempt never pulses `double_tap`. After a failed window the block returns to idle (`busy` low).
- R9: `thresh` = 0 or `dur_max` = 0 disables all detection. `latency` = 0 or `window` = 0 disables only double taps; single taps then behave as in R3.
- R10: Only samples with `sample_vld` high advance the block. Each pulse lasts one clock and appears in the cycle after the strobe clock edge. `busy` is high whenever the state is not idle.
- R11: A synchronous `rst` returns the block to idle, with `busy`, `single_tap` and `double_tap` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_vld | input | 1 | Sample strobe |
| sample | input | SAMPLE_W | Signed acceleration sample |
| thresh | input | SAMPLE_W | Unsigned magnitude threshold |
| dur_max | input | CNT_W | Maximum impulse length in samples |
| latency | input | CNT_W | Dead time after the first impulse, in samples |
| window | input | CNT_W | Second-impulse start window, in samples |
| single_en | input | 1 | Single tap reporting enable |
| double_en | input | 1 | Double tap reporting enable |
| single_tap | output | 1 | One-cycle single tap pulse |
| double_tap | output | 1 | One-cycle double tap pulse |
| busy | output | 1 | State machine not idle |

## Verification
A wrong state or a counter that is off by one shows up at the ports as a pulse on the wrong sample, or as a missing or spurious pulse. The first symptom appears within one strobe of the phase boundary that went wrong, such as the end of the latency, the last window sample, or the sample at the length limit. The bench therefore checks the exact sample index of each pulse across sequences placed on those boundaries. It also watches `busy` to expose a machine stuck outside idle, or one that left idle when it should not have.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_LATENT,
        ST_WIN_LOW,
        ST_WIN_ARM,
        ST_SECOND,
        ST_OVER
    } tap_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD,
        CNT_ONE,
        CNT_INC
    } cnt_op_e;
endpackage

// File: rtl/tap_mag_cmp.sv
`timescale 1ns/1ps
module tap_mag_cmp #(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [SAMPLE_W-1:0] thresh,
    output logic                       above
);
    logic [SAMPLE_W-1:0] mag;

    // two's complement absolute value, held unsigned so the most negative fits
    always_comb begin
        if (sample[SAMPLE_W-1]) mag = ~sample + 1'b1;
        else                    mag = sample;
        above = (mag > thresh);
    end

    always_comb begin
        AST_EQUAL_NOT_ABOVE: assert (!(mag == thresh) || !above); // R1
    end
endmodule

// File: rtl/tap_step_counter.sv
`timescale 1ns/1ps
module tap_step_counter #(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  tap_pkg::cnt_op_e   op,
    input  logic [CNT_W-1:0]   limit,
    output logic               at_limit
);
    import tap_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_ONE:  cnt_q <= ONE;
                CNT_INC:  cnt_q <= cnt_q + ONE;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign at_limit = (cnt_q == limit);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op == CNT_INC) |-> (cnt_q != '1)); // R2
endmodule

// File: rtl/tap_classifier.sv
`timescale 1ns/1ps
module tap_classifier #(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_vld,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic        [SAMPLE_W-1:0] thresh,
    input  logic        [CNT_W-1:0]    dur_max,
    input  logic        [CNT_W-1:0]    latency,
    input  logic        [CNT_W-1:0]    window,
    input  logic                       single_en,
    input  logic                       double_en,
    output logic                       single_tap,
    output logic                       double_tap,
    output logic                       busy
);
    import tap_pkg::*;

    tap_state_e       state_q, state_d;
    cnt_op_e          cnt_op;
    logic [CNT_W-1:0] cnt_limit;
    logic             at_limit;
    logic             above;
    logic             dbl_live;
    logic             tap_live;
    logic             fire_s, fire_d;

    tap_mag_cmp #(.SAMPLE_W(SAMPLE_W)) u_mag (
        .sample (sample),
        .thresh (thresh),
        .above  (above)
    );

    tap_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (cnt_op),
        .limit    (cnt_limit),
        .at_limit (at_limit)
    );

    // double taps need a non-empty latency and window; any tap needs a threshold and length
    assign dbl_live = double_en && (latency != '0) && (window != '0);
    assign tap_live = (thresh != '0) && (dur_max != '0) && (single_en || dbl_live);

    // the single counter serves whichever phase is active
    always_comb begin
        unique case (state_q)
            ST_LATENT:              cnt_limit = latency;
            ST_WIN_LOW, ST_WIN_ARM: cnt_limit = window;
            default:                cnt_limit = dur_max;
        endcase
    end

    // next state, counter command and report requests
    always_comb begin
        state_d = state_q;
        cnt_op  = CNT_HOLD;
        fire_s  = 1'b0;
        fire_d  = 1'b0;
        if (sample_vld) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (tap_live && above) begin
                        state_d = ST_FIRST;
                        cnt_op  = CNT_ONE;
                    end
                end
                ST_FIRST: begin
                    if (!above) begin
                        if (dbl_live) begin
                            state_d = ST_LATENT;
                            cnt_op  = CNT_ONE;
                        end else begin
                            fire_s  = single_en;
                            state_d = ST_IDLE;
                        end
                    end else if (at_limit) begin
                        state_d = ST_OVER;
                    end else begin
                        cnt_op = CNT_INC;
                    end
                end
                ST_LATENT: begin
                    if (at_limit) begin
                        state_d = above ? ST_WIN_LOW : ST_WIN_ARM;
                        cnt_op  = CNT_ONE;
                    end else begin
                        cnt_op = CNT_INC;
                    end
                end
                ST_WIN_LOW: begin
                    if (at_limit) begin
                        fire_s  = single_en;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_op = CNT_INC;
                        if (!above) state_d = ST_WIN_ARM;
                    end
                end
                ST_WIN_ARM: begin
                    if (above) begin
                        state_d = ST_SECOND;
                        cnt_op  = CNT_ONE;
                    end else if (at_limit) begin
                        fire_s  = single_en;
                        state_d = ST_IDLE;
                    end else begin
                        cnt_op = CNT_INC;
                    end
                end
                ST_SECOND: begin
                    if (!above) begin
                        fire_d  = 1'b1;
                        fire_s  = single_en;
                        state_d = ST_IDLE;
                    end else if (at_limit) begin
                        fire_s  = single_en;
                        state_d = ST_OVER;
                    end else begin
                        cnt_op = CNT_INC;
                    end
                end
                ST_OVER: begin
                    if (!above) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            single_tap <= 1'b0;
            double_tap <= 1'b0;
            busy       <= 1'b0;
        end else begin
            single_tap <= fire_s;
            double_tap <= fire_d;
            busy       <= (state_d != ST_IDLE);
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy && !single_tap && !double_tap)); // R11
    AST_PULSE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (single_tap || double_tap) |-> $past(sample_vld)); // R10
    AST_SINGLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        single_tap |=> !single_tap); // R10
    AST_DOUBLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        double_tap |=> !double_tap); // R10
    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        !sample_vld |=> $stable(state_q)); // R10
    AST_DOUBLE_ENDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        double_tap |-> !busy); // R8
    AST_SINGLE_WITH_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (double_tap && $past(single_en)) |-> single_tap); // R7
    AST_DOUBLE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        double_tap |-> $past(double_en)); // R9
endmodule

// File: tb/tb_tap_classifier.sv
`timescale 1ns/1ps
module tb_tap_classifier;
    localparam int SW = 16;
    localparam int CW = 8;
    localparam logic [4:0] NONE = 5'd31;

    typedef struct packed {
        logic [15:0] mask;
        logic [4:0]  len;
        logic [7:0]  dur;
        logic [7:0]  lat;
        logic [7:0]  win;
        logic        sen;
        logic        den;
        logic [4:0]  es;
        logic [4:0]  ed;
    } vec_t;

    // sample i is high when mask bit i is set; es/ed = sample index whose strobe yields the pulse
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'h0006, 5'd6,  8'd3, 8'd2, 8'd3, 1'b1, 1'b0, 5'd3,  5'd31}, // R3 single only
        '{16'h001E, 5'd8,  8'd3, 8'd2, 8'd3, 1'b1, 1'b0, 5'd31, 5'd31}, // R2 too long
        '{16'h000E, 5'd6,  8'd3, 8'd2, 8'd3, 1'b1, 1'b0, 5'd4,  5'd31}, // R2 exactly dur
        '{16'h0022, 5'd10, 8'd3, 8'd2, 8'd3, 1'b0, 1'b1, 5'd31, 5'd6 }, // R6 double only
        '{16'h0022, 5'd10, 8'd3, 8'd2, 8'd3, 1'b1, 1'b1, 5'd6,  5'd6 }, // R7 both, success
        '{16'h0002, 5'd10, 8'd3, 8'd2, 8'd3, 1'b1, 1'b1, 5'd7,  5'd31}, // R8 window expires
        '{16'h000A, 5'd10, 8'd3, 8'd2, 8'd3, 1'b1, 1'b1, 5'd7,  5'd31}, // R4 high in latency
        '{16'h0182, 5'd12, 8'd3, 8'd2, 8'd3, 1'b1, 1'b1, 5'd9,  5'd9 }, // R6 ends after window
        '{16'h01E2, 5'd12, 8'd3, 8'd2, 8'd3, 1'b1, 1'b1, 5'd8,  5'd31}, // R7 second too long
        '{16'h0032, 5'd10, 8'd3, 8'd2, 8'd3, 1'b1, 1'b1, 5'd7,  5'd31}, // R5 high at open
        '{16'h0002, 5'd6,  8'd3, 8'd0, 8'd3, 1'b1, 1'b1, 5'd2,  5'd31}, // R9 latency zero
        '{16'h0002, 5'd10, 8'd3, 8'd2, 8'd3, 1'b0, 1'b1, 5'd31, 5'd31}, // R8 double only fails
        '{16'h0022, 5'd10, 8'd3, 8'd2, 8'd3, 1'b0, 1'b0, 5'd31, 5'd31}, // R9 nothing enabled
        '{16'h0002, 5'd4,  8'd3, 8'd2, 8'd0, 1'b1, 1'b1, 5'd2,  5'd31}, // R9 window zero
        '{16'h0082, 5'd10, 8'd3, 8'd4, 8'd1, 1'b1, 1'b1, 5'd8,  5'd8 }, // R5 last window sample
        '{16'h0022, 5'd10, 8'd1, 8'd2, 8'd3, 1'b1, 1'b1, 5'd6,  5'd6 }  // R2 one-sample taps
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 sample_vld = 1'b0;
    logic signed [SW-1:0] sample = '0;
    logic [SW-1:0]        thresh = 16'd100;
    logic [CW-1:0]        dur_max = 8'd3;
    logic [CW-1:0]        latency = 8'd2;
    logic [CW-1:0]        window = 8'd3;
    logic                 single_en = 1'b1;
    logic                 double_en = 1'b0;
    logic                 single_tap, double_tap, busy;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tap_classifier #(.SAMPLE_W(SW), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .sample_vld(sample_vld), .sample(sample),
        .thresh(thresh), .dur_max(dur_max), .latency(latency), .window(window),
        .single_en(single_en), .double_en(double_en),
        .single_tap(single_tap), .double_tap(double_tap), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with outputs settled
    task automatic push(input logic vld, input logic signed [SW-1:0] val);
        sample_vld = vld;
        sample     = val;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push(1'b0, '0);
        push(1'b0, '0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R11 reset state
        check(!busy && !single_tap && !double_tap, "R11 reset state",
              {busy, single_tap, double_tap}, 0);

        for (int v = 0; v < NV; v++) begin
            int errs;
            int act_s;
            int act_d;
            errs  = 0;
            act_s = NONE;
            act_d = NONE;
            dur_max   = VECS[v].dur;
            latency   = VECS[v].lat;
            window    = VECS[v].win;
            single_en = VECS[v].sen;
            double_en = VECS[v].den;
            do_reset();
            for (int i = 0; i < int'(VECS[v].len); i++) begin
                logic signed [SW-1:0] val;
                if (VECS[v].mask[i]) val = (i % 2 == 1) ? -16'sd300 : 16'sd300;
                else                 val = 16'sd20;
                push(1'b1, val);
                if (single_tap) act_s = i;
                if (double_tap) act_d = i;
                if (single_tap != (i == int'(VECS[v].es))) errs++;
                if (double_tap != (i == int'(VECS[v].ed))) errs++;
            end
            check(errs == 0, $sformatf("vector %0d single idx", v), act_s, int'(VECS[v].es));
            check(errs == 0, $sformatf("vector %0d double idx", v), act_d, int'(VECS[v].ed));
        end

        // directed: R1 equal magnitude is low
        dur_max = 8'd3; latency = 8'd2; window = 8'd3; single_en = 1'b1; double_en = 1'b0;
        do_reset();
        push(1'b1, -16'sd100);
        check(!busy, "R1 equal magnitude", busy, 0);

        // R1 most negative sample
        thresh = 16'h7FFF;
        push(1'b1, 16'sh8000);
        check(busy, "R1 most negative busy", busy, 1);
        push(1'b1, 16'sd0);
        check(single_tap, "R1 most negative pulse", single_tap, 1);
        thresh = 16'd100;

        // R10 strobe gating and pulse width
        do_reset();
        push(1'b1, 16'sd400);
        push(1'b0, 16'sd0);
        push(1'b0, 16'sd0);
        push(1'b0, 16'sd0);
        check(busy && !single_tap, "R10 no strobe no advance", {busy, single_tap}, 2);
        push(1'b1, 16'sd0);
        check(single_tap, "R10 pulse on strobe", single_tap, 1);
        push(1'b0, 16'sd0);
        check(!single_tap && !busy, "R10 one-cycle pulse", {single_tap, busy}, 0);

        // R2 busy during over-long run, then idle with no pulse
        do_reset();
        for (int i = 0; i < 5; i++) push(1'b1, 16'sd400);
        check(busy, "R2 busy while too long", busy, 1);
        push(1'b1, 16'sd0);
        check(!busy && !single_tap, "R2 release no pulse", {busy, single_tap}, 0);

        // R9 zero threshold
        thresh = '0;
        do_reset();
        push(1'b1, 16'sd400);
        check(!busy, "R9 zero threshold", busy, 0);
        thresh = 16'd100;

        // R9 zero duration
        dur_max = '0;
        do_reset();
        push(1'b1, 16'sd400);
        check(!busy, "R9 zero duration", busy, 0);
        dur_max = 8'd3;

        // R11 reset mid-sequence
        single_en = 1'b1; double_en = 1'b1;
        do_reset();
        push(1'b1, 16'sd400);
        push(1'b1, 16'sd0);
        check(busy, "R11 busy in latency", busy, 1);
        rst = 1'b1;
        push(1'b0, 16'sd0);
        rst = 1'b0;
        check(!busy, "R11 reset clears busy", busy, 0);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 10; i++) begin
                push(1'b1, 16'sd0);
                if (single_tap || double_tap) seen++;
            end
            check(seen == 0, "R11 no pulse after reset", seen, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule